// File: doc/BRIEF.md
# Integer Lifting Half-Band Wavelet Stage

This block performs one level of an integer-to-integer wavelet split, and also the matching merge, on fixed-length frames of signed samples. It does all of its arithmetic with shifts and adds, and has no multipliers. In the forward direction a frame of samples is taken in and split into even and odd positions. Each even sample is passed on unchanged as a coarse coefficient. Each odd sample is replaced by a detail coefficient: the odd sample minus a rounded cubic interpolation of it. The interpolation uses the four nearest even samples with weights -1, 9, 9, -1 over 16.

In the inverse direction the block receives a frame of interleaved coarse and detail coefficients. It adds back the same rounded prediction, and so recovers the original samples bit for bit. The prediction depends only on the even positions, and these are identical in both directions. For this reason one datapath serves both directions; only the sign of the correction changes.

Samples enter and leave on valid/ready streams. A whole frame is collected first and then emitted, in index order.

Top module: `lift_halfband_stage`

## Requirements
- R1: At reset release `inReady` is 1 and `outValid` is 0.
- R2: In forward mode, output word at frame position 2n equals input word 2n (coarse value unchanged). Outputs are emitted in frame position order 0..FRAME_LEN-1.
- R3: In forward mode, output word at frame position 2n+1 equals x[2n+1] - ((9*(x[2n]+x[2n+2]) - (x[2n-2]+x[2n+4]) + 8) >>> 4), where >>> is an arithmetic shift.
- R4: Positions outside the frame are mirrored about the end samples: x[-2] = x[2], x[L] = x[L-2] and x[L+2] = x[L-4] for frame length L.
- R5: In inverse mode (mode input 1), even positions pass unchanged and odd output 2n+1 equals the input detail plus the same rounded prediction. A forward frame followed by an inverse frame of its outputs reproduces the original samples exactly.
- R6: If the samples of a forward frame lie on a cubic polynomial, every detail whose four neighbours are inside the frame is 0.
- R7: Stream rules: `inReady` and `outValid` are never high together. A frame of exactly FRAME_LEN accepted words is followed by FRAME_LEN output words. While `outValid` is high and `outReady` is low, `outData` holds.
- R8: The mode is sampled with the first accepted word of a frame. Changes to `invMode` during the rest of the frame have no effect on that frame.

FRAME_LEN must be even and at least 8. In forward mode, inputs must lie in the signed SAMPLE_W range. Ports are SAMPLE_W+2 bits wide so that detail values fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| invMode | input | 1 | 0 = forward split, 1 = inverse merge; sampled with the first word of a frame |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Block is accepting frame words |
| inData | input | SAMPLE_W+2 | Signed sample or coefficient |
| outValid | output | 1 | Output word present |
| outReady | input | 1 | Sink takes the output word |
| outData | output | SAMPLE_W+2 | Signed coefficient or recovered sample |

## Verification
A wrong stored sample or a wrong neighbour index would show up as a mismatched word in that same frame. The error appears at the first odd position that uses the bad even sample, and at most three positions later than the bad sample itself. A wrong latched mode flips the sign of the correction on every odd word of the frame, so the second output word already differs. A counter fault would show within one frame as a missing or extra output word, or as a word released while the sink stalls. The reference model predicts each word ahead of time and compares it on every handshake.

// File: rtl/lift_pkg.sv
package lift_pkg;
  typedef enum logic {ST_LOAD = 1'b0, ST_EMIT = 1'b1} liftState_t;

  typedef struct packed {
    logic wrEn;
    logic emit;
    logic invert;
  } liftStrobe_t;
endpackage

// File: rtl/lift_ctrl.sv
module lift_ctrl
  import lift_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  localparam int IDXW = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            invMode,
  input  logic            inValid,
  output logic            inReady,
  output logic            outValid,
  input  logic            outReady,
  output liftStrobe_t     strobes,
  output logic [IDXW-1:0] idx
);
  liftState_t state;
  logic [IDXW-1:0] cnt;
  logic modeLat;
  logic lastPos;

  assign lastPos  = (cnt == IDXW'(FRAME_LEN - 1));
  assign inReady  = (state == ST_LOAD);
  assign outValid = (state == ST_EMIT);
  assign idx      = cnt;

  always_comb begin
    strobes.wrEn   = inReady && inValid;
    strobes.emit   = outValid;
    // the first word of a frame carries its own mode bit
    strobes.invert = (inReady && cnt == '0) ? invMode : modeLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_LOAD;
      cnt     <= '0;
      modeLat <= 1'b0;
    end else if (state == ST_LOAD) begin
      if (inValid) begin
        if (cnt == '0) modeLat <= invMode;
        if (lastPos) begin
          state <= ST_EMIT;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (outReady) begin
      if (lastPos) begin
        state <= ST_LOAD;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7: loading and emitting never overlap
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));
  // R7: output phase only begins right after an accepted input word
  assert_emit_after_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));
  // R7: a stalled output keeps its position
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(idx)));
  // R8: the mode does not move while a frame is emitted
  assert_mode_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> $stable(modeLat));
endmodule

// File: rtl/lift_dp.sv
module lift_dp
  import lift_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int FRAME_LEN = 16,
  localparam int WORD_W = SAMPLE_W + 2,
  localparam int SUM_W  = WORD_W + 5,
  localparam int IDXW   = $clog2(FRAME_LEN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  liftStrobe_t              strobes,
  input  logic [IDXW-1:0]          idx,
  input  logic signed [WORD_W-1:0] inData,
  output logic signed [WORD_W-1:0] outData
);
  logic signed [WORD_W-1:0] frameMem [FRAME_LEN];
  logic signed [WORD_W-1:0] cur, nearL, nearR, farL, farR;
  logic signed [SUM_W-1:0]  pairNear, pairFar, scaled, pred, full;

  function automatic logic [IDXW-1:0] mirrorIdx(input int pos);
    int m;
    if (pos < 0) m = -pos;
    else if (pos > FRAME_LEN - 1) m = 2 * (FRAME_LEN - 1) - pos;
    else m = pos;
    return IDXW'(m);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.wrEn) frameMem[idx] <= inData;
  end

  always_comb begin
    cur      = frameMem[idx];
    nearL    = frameMem[mirrorIdx(int'(idx) - 1)];
    nearR    = frameMem[mirrorIdx(int'(idx) + 1)];
    farL     = frameMem[mirrorIdx(int'(idx) - 3)];
    farR     = frameMem[mirrorIdx(int'(idx) + 3)];
    pairNear = SUM_W'(nearL) + SUM_W'(nearR);
    pairFar  = SUM_W'(farL) + SUM_W'(farR);
    scaled   = (pairNear <<< 3) + pairNear - pairFar + SUM_W'(8);
    pred     = scaled >>> 4;
    full     = strobes.invert ? SUM_W'(cur) + pred : SUM_W'(cur) - pred;
    outData  = idx[0] ? full[WORD_W-1:0] : cur;
  end

  // R2: coarse words emitted stay inside the sample range
  assert_even_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && !idx[0]) |->
      (outData >= -(2 ** (SAMPLE_W - 1)) && outData < 2 ** (SAMPLE_W - 1)));
  // R3: the corrected odd word fits the port width
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && idx[0]) |-> (full == SUM_W'(outData)));
endmodule

// File: rtl/lift_halfband_stage.sv
module lift_halfband_stage
  import lift_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int FRAME_LEN = 16,
  localparam int WORD_W = SAMPLE_W + 2,
  localparam int IDXW   = $clog2(FRAME_LEN)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     invMode,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [WORD_W-1:0] inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [WORD_W-1:0] outData
);
  liftStrobe_t     strobes;
  logic [IDXW-1:0] idx;

  lift_ctrl #(.FRAME_LEN(FRAME_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .invMode(invMode), .inValid(inValid),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .strobes(strobes), .idx(idx)
  );

  lift_dp #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .idx(idx),
    .inData(inData), .outData(outData)
  );
endmodule

// File: tb/sim_lift_halfband_stage.sv
module sim_lift_halfband_stage;
  localparam int SW = 16;
  localparam int L  = 16;
  localparam int WW = SW + 2;

  logic clk = 0, rstN = 0, invMode = 0, inValid = 0, outReady = 0;
  logic signed [WW-1:0] inData = '0;
  logic inReady, outValid;
  logic signed [WW-1:0] outData;

  int tests = 0, fails = 0, cycles = 0;
  int expQ[$];
  string tagQ[$];
  bit stallPrev = 0;
  int heldData = 0;

  always #10 clk = ~clk;

  lift_halfband_stage #(.SAMPLE_W(SW), .FRAME_LEN(L)) u0 (
    .clk(clk), .rstN(rstN), .invMode(invMode), .inValid(inValid),
    .inReady(inReady), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData)
  );

  task automatic check(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int mir(int i);
    if (i < 0) return -i;
    if (i > L - 1) return 2 * (L - 1) - i;
    return i;
  endfunction

  function automatic int predAt(int x[L], int odd);
    int s;
    s = 9 * (x[mir(odd - 1)] + x[mir(odd + 1)]) - (x[mir(odd - 3)] + x[mir(odd + 3)]) + 8;
    return s >>> 4;
  endfunction

  task automatic sendWord(int d, bit m);
    @(negedge clk);
    if ($urandom_range(0, 3) == 0) begin
      inValid = 0;
      @(negedge clk);
    end
    inValid = 1; inData = WW'(d); invMode = m;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 0;
  endtask

  // forward frame; tag odd positions by whether mirroring is involved
  task automatic fwdFrame(int x[L], bit cubic, bit modeFlip, output int c[L]);
    for (int i = 0; i < L; i++) begin
      if (i % 2 == 0) c[i] = x[i];
      else c[i] = x[i] - predAt(x, i);
    end
    for (int i = 0; i < L; i++) begin
      bit edgePos = (i == 1) || (i >= L - 3);
      if (modeFlip) begin expQ.push_back(c[i]); tagQ.push_back("R8"); end
      else if (i % 2 == 0) begin expQ.push_back(x[i]); tagQ.push_back("R2"); end
      else if (edgePos) begin expQ.push_back(c[i]); tagQ.push_back("R4"); end
      else if (cubic) begin expQ.push_back(0); tagQ.push_back("R6"); end
      else begin expQ.push_back(c[i]); tagQ.push_back("R3"); end
    end
    for (int i = 0; i < L; i++) sendWord(x[i], (modeFlip && i > 0) ? 1'b1 : 1'b0);
  endtask

  // inverse frame: the expected output is the original sample set
  task automatic invFrame(int c[L], int x[L]);
    for (int i = 0; i < L; i++) begin expQ.push_back(x[i]); tagQ.push_back("R5"); end
    for (int i = 0; i < L; i++) sendWord(c[i], (i == 0) ? 1'b1 : (i % 3 == 0));
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (stallPrev) begin
        check("R7 stall hold valid", int'(outValid), 1);
        check("R7 stall hold data", int'(outData), heldData);
      end
      check("R7 no overlap", int'(inReady && outValid), 0);
      outReady = ($urandom_range(0, 3) != 0);
      if (outValid && outReady) begin
        if (expQ.size() == 0) check("R7 extra output", 1, 0);
        else check(tagQ.pop_front(), int'(outData), expQ.pop_front());
      end
      stallPrev = outValid && !outReady;
      heldData  = int'(outData);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int x[L], c[L], y[L];
    #25;
    check("R1 inReady after reset", int'(inReady), 1);
    check("R1 outValid after reset", int'(outValid), 0);
    rstN = 1;
    // impulse near each frame edge
    for (int i = 0; i < L; i++) x[i] = (i == 2 || i == L - 2) ? 1000 : 0;
    fwdFrame(x, 0, 0, c);
    // extreme values
    for (int i = 0; i < L; i++) x[i] = (i % 4 < 2) ? 32767 : -32768;
    fwdFrame(x, 0, 0, c);
    invFrame(c, x);
    // cubic ramp
    for (int i = 0; i < L; i++) x[i] = i * i * i - 9 * i * i + 3 * i - 7;
    fwdFrame(x, 1, 0, c);
    // mode change after the first word is ignored
    for (int i = 0; i < L; i++) x[i] = int'($urandom_range(0, 2000)) - 1000;
    fwdFrame(x, 0, 1, c);
    // random round trips
    for (int f = 0; f < 12; f++) begin
      for (int i = 0; i < L; i++) x[i] = int'($urandom_range(0, 65535)) - 32768;
      fwdFrame(x, 0, 0, c);
      invFrame(c, x);
      y = x;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule